// File: doc/BRIEF.md
# Debug Serial Port with Status Flags

This block is a small serial port for console and debug traffic, placed on a 32-bit register bus. Software writes a byte to a transmit register. The block then sends it on a single output line as one start bit, eight data bits with the least significant bit first, and one stop bit. Bytes arriving on the input line are checked at the middle of each bit, using sixteen samples per bit time. Each received byte is placed in a receive register for software to collect.

A set of sticky status flags reports the state of the port:
- receive data waiting
- transmitter ready for another byte
- transmitter fully idle
- receive overrun
- stop-bit (framing) error

An interrupt mask selects which of these flags drive a single level-sensitive interrupt line. Software sets mask bits through one register and clears them through another, and it reads the mask through a third, read-only register. One bit time lasts 16 times the programmed divisor, counted in system clocks.

Top module: `serial_dbg_port`

## Requirements
- R1: After reset the status register (byte offset 0x14) reads 0x202 (bit 9 transmitter idle, bit 1 transmitter ready). The control (0x00), mode (0x04), mask (0x10), receive (0x18) and divisor (0x20) registers read 0. The interrupt output is low and the serial output is high.
- R2: The mode register (0x04) and the divisor register (0x20) read back the value last written. The divisor occupies the low DIV_W bits.
- R3: A write to offset 0x08 ORs the written value into the mask. A write to 0x0C clears the written bits from the mask. A write to the mask register (0x10) has no effect.
- R4: A write to the transmit register (0x1C) is accepted when the transmitter is enabled and status bit 1 is set. Acceptance clears status bits 1 and 9. The output then carries a low start bit, the eight data bits LSB first and a high stop bit, each lasting 16 x divisor clocks. The first bit starts on the clock after the write.
- R5: Status bits 1 and 9 are set again exactly 10 bit times after the accepted write.
- R6: A write to the transmit register while status bit 1 is clear is ignored and does not disturb the byte in progress.
- R7: Writing control bit 7 disables the transmitter and clears status bits 1 and 9. Writing control bit 6, when bit 7 is not also written, enables the transmitter. If no byte is shifting, this sets both flags. While the transmitter is disabled, writes to the transmit register are ignored.
- R8: A received byte with a high stop bit is loaded into the receive register and sets status bit 0. A read of the receive register (0x18) clears status bit 0.
- R9: A byte that completes while status bit 0 is set sets the overrun flag (status bit 5) and replaces the receive register contents.
- R10: A byte whose stop bit is sampled low sets the framing flag (status bit 6). It still loads the receive register and sets status bit 0.
- R11: Writing control bit 8 clears status bits 5 and 6 and leaves the other status bits unchanged.
- R12: The interrupt output is high exactly when the bitwise AND of the mask and the status register is nonzero.
- R13: Writing control bit 5 (or bit 2) disables the receiver, so an incoming byte changes neither the status nor the receive register. Writing control bit 4 alone re-enables the receiver.
- R14: Writing control bit 3 aborts a byte in progress: the serial output returns high, the transmitter is disabled and status bits 1 and 9 are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the port with DIV_W of 8, leaving ADDR_W at 6 and the oversampling factor at 16. It programs divisors of 1 and 3, so a full frame takes only 160 or 480 clocks. This keeps the exact 10-bit-time flag recovery and every bit edge of the output line within a short run. At divisor 1, the receive paths can be reached in a few hundred cycles each: back-to-back bytes causing overrun, a low stop bit, and a byte arriving while the receiver is off. The serial output and the interrupt line are compared against a behavioural model on every clock.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
    // register byte offsets (software decodes these)
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_MODE  = 'h04;
    localparam int OFF_IEN   = 'h08;
    localparam int OFF_IDIS  = 'h0C;
    localparam int OFF_IMASK = 'h10;
    localparam int OFF_STAT  = 'h14;
    localparam int OFF_RXD   = 'h18;
    localparam int OFF_TXD   = 'h1C;
    localparam int OFF_BAUD  = 'h20;
    // control bits
    localparam int CB_RST_RX  = 2;
    localparam int CB_RST_TX  = 3;
    localparam int CB_RX_ON   = 4;
    localparam int CB_RX_OFF  = 5;
    localparam int CB_TX_ON   = 6;
    localparam int CB_TX_OFF  = 7;
    localparam int CB_CLR_ERR = 8;
    // status bits
    localparam int SB_RX_FULL = 0;
    localparam int SB_TX_FREE = 1;
    localparam int SB_OVERRUN = 5;
    localparam int SB_FRAMING = 6;
    localparam int SB_TX_IDLE = 9;
    // frame: start + 8 data + stop
    localparam int FRAME_BITS = 10;
endpackage

// File: rtl/sdp_tx.sv
module sdp_tx import sdp_pkg::*; #(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             load,
    input  logic             abort,
    input  logic [7:0]       byte_in,
    output logic             txd,
    output logic             busy,
    output logic             done
);
    localparam int SUB_W = $clog2(OVS);

    typedef struct packed {
        logic                  busy;
        logic [DIV_W-1:0]      pre;
        logic [SUB_W-1:0]      sub;
        logic [3:0]            bitn;
        logic [FRAME_BITS-1:0] sh;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        done = 1'b0;
        if (abort) begin
            tx_d.busy = 1'b0;
        end else if (load) begin
            tx_d.busy = 1'b1;
            tx_d.pre  = '0;
            tx_d.sub  = '0;
            tx_d.bitn = '0;
            tx_d.sh   = {1'b1, byte_in, 1'b0};
        end else if (tx_q.busy && div != '0) begin
            if (tx_q.pre == div - DIV_W'(1)) begin
                tx_d.pre = '0;
                if (tx_q.sub == SUB_W'(OVS - 1)) begin
                    tx_d.sub  = '0;
                    tx_d.sh   = {1'b1, tx_q.sh[FRAME_BITS-1:1]};
                    tx_d.bitn = tx_q.bitn + 4'd1;
                    if (tx_q.bitn == 4'(FRAME_BITS - 1)) begin
                        tx_d.busy = 1'b0;
                        done      = 1'b1;
                    end
                end else begin
                    tx_d.sub = tx_q.sub + SUB_W'(1);
                end
            end else begin
                tx_d.pre = tx_q.pre + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign txd  = !tx_q.busy || tx_q.sh[0];
    assign busy = tx_q.busy;
endmodule

// File: rtl/sdp_rx.sv
module sdp_rx import sdp_pkg::*; #(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             en,
    input  logic             rxd,
    output logic             valid,
    output logic             ferr,
    output logic [7:0]       byte_out
);
    localparam int SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] MID = SUB_W'(OVS / 2 - 1);

    typedef struct packed {
        logic [1:0]       sync;
        logic             busy;
        logic [DIV_W-1:0] pre;
        logic [SUB_W-1:0] sub;
        logic [3:0]       bitn;
        logic [7:0]       sh;
    } rx_t;

    rx_t  rx_d, rx_q;
    logic line;

    assign line = rx_q.sync[1];

    always_comb begin
        rx_d      = rx_q;
        rx_d.sync = {rx_q.sync[0], rxd};
        valid     = 1'b0;
        ferr      = 1'b0;
        if (!en) begin
            rx_d.busy = 1'b0;
        end else if (!rx_q.busy) begin
            if (!line) begin
                rx_d.busy = 1'b1;
                rx_d.pre  = '0;
                rx_d.sub  = '0;
                rx_d.bitn = '0;
            end
        end else if (div != '0) begin
            if (rx_q.pre == div - DIV_W'(1)) begin
                rx_d.pre = '0;
                rx_d.sub = rx_q.sub + SUB_W'(1);
                if (rx_q.sub == MID) begin
                    rx_d.bitn = rx_q.bitn + 4'd1;
                    if (rx_q.bitn == 4'd0) begin
                        if (line) rx_d.busy = 1'b0;   // false start
                    end else if (rx_q.bitn == 4'(FRAME_BITS - 1)) begin
                        valid     = 1'b1;
                        ferr      = !line;
                        rx_d.busy = 1'b0;
                    end else begin
                        rx_d.sh = {line, rx_q.sh[7:1]};
                    end
                end
            end else begin
                rx_d.pre = rx_q.pre + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '{sync: 2'b11, default: '0};
        else        rx_q <= rx_d;
    end

    assign byte_out = rx_q.sh;
endmodule

// File: rtl/serial_dbg_port.sv
module serial_dbg_port import sdp_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int DIV_W  = 16,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              txd,
    input  logic              rxd,
    output logic              irq
);
    typedef struct packed {
        logic [31:0]      mask;
        logic [31:0]      mode;
        logic [DIV_W-1:0] div;
        logic [7:0]       rhr;
        logic             rxrdy;
        logic             txrdy;
        logic             txempty;
        logic             ovre;
        logic             frame;
        logic             tx_en;
        logic             rx_en;
    } regs_t;

    regs_t       regs_d, regs_q;
    logic        wr_hit, rd_hit;
    logic        tx_load, tx_abort, tx_busy, tx_done;
    logic        rx_valid, rx_ferr;
    logic [7:0]  rx_byte;
    logic [31:0] stat_vec;

    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && !bus_wr;

    always_comb begin
        stat_vec             = '0;
        stat_vec[SB_RX_FULL] = regs_q.rxrdy;
        stat_vec[SB_TX_FREE] = regs_q.txrdy;
        stat_vec[SB_OVERRUN] = regs_q.ovre;
        stat_vec[SB_FRAMING] = regs_q.frame;
        stat_vec[SB_TX_IDLE] = regs_q.txempty;
    end

    always_comb begin
        regs_d   = regs_q;
        tx_load  = 1'b0;
        tx_abort = 1'b0;
        // character finished shifting
        if (tx_done && regs_q.tx_en) begin
            regs_d.txrdy   = 1'b1;
            regs_d.txempty = 1'b1;
        end
        // receive path: a new byte wins over a same-cycle read
        if (rx_valid) begin
            if (regs_q.rxrdy) regs_d.ovre = 1'b1;
            if (rx_ferr)      regs_d.frame = 1'b1;
            regs_d.rhr   = rx_byte;
            regs_d.rxrdy = 1'b1;
        end else if (rd_hit && bus_addr == ADDR_W'(OFF_RXD)) begin
            regs_d.rxrdy = 1'b0;
        end
        if (wr_hit) begin
            case (bus_addr)
                ADDR_W'(OFF_CTRL): begin
                    if (bus_wdata[CB_RST_RX] || bus_wdata[CB_RX_OFF]) regs_d.rx_en = 1'b0;
                    else if (bus_wdata[CB_RX_ON])                      regs_d.rx_en = 1'b1;
                    if (bus_wdata[CB_RST_TX] || bus_wdata[CB_TX_OFF]) begin
                        regs_d.tx_en   = 1'b0;
                        regs_d.txrdy   = 1'b0;
                        regs_d.txempty = 1'b0;
                        tx_abort       = bus_wdata[CB_RST_TX];
                    end else if (bus_wdata[CB_TX_ON]) begin
                        regs_d.tx_en = 1'b1;
                        if (!tx_busy) begin
                            regs_d.txrdy   = 1'b1;
                            regs_d.txempty = 1'b1;
                        end
                    end
                    if (bus_wdata[CB_CLR_ERR]) begin
                        regs_d.ovre  = 1'b0;
                        regs_d.frame = 1'b0;
                    end
                end
                ADDR_W'(OFF_MODE): regs_d.mode = bus_wdata;
                ADDR_W'(OFF_IEN):  regs_d.mask = regs_q.mask | bus_wdata;
                ADDR_W'(OFF_IDIS): regs_d.mask = regs_q.mask & ~bus_wdata;
                ADDR_W'(OFF_TXD): begin
                    if (regs_q.tx_en && regs_q.txrdy) begin
                        tx_load        = 1'b1;
                        regs_d.txrdy   = 1'b0;
                        regs_d.txempty = 1'b0;
                    end
                end
                ADDR_W'(OFF_BAUD): regs_d.div = bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{txrdy: 1'b1, txempty: 1'b1, tx_en: 1'b1, rx_en: 1'b1, default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFF_MODE):  bus_rdata = regs_q.mode;
            ADDR_W'(OFF_IMASK): bus_rdata = regs_q.mask;
            ADDR_W'(OFF_STAT):  bus_rdata = stat_vec;
            ADDR_W'(OFF_RXD):   bus_rdata = {24'd0, regs_q.rhr};
            ADDR_W'(OFF_BAUD):  bus_rdata = 32'(regs_q.div);
            default:            bus_rdata = '0;
        endcase
    end

    assign irq = |(regs_q.mask & stat_vec);

    sdp_tx #(.DIV_W(DIV_W), .OVS(OVS)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (regs_q.div),
        .load    (tx_load),
        .abort   (tx_abort),
        .byte_in (bus_wdata[7:0]),
        .txd     (txd),
        .busy    (tx_busy),
        .done    (tx_done)
    );

    sdp_rx #(.DIV_W(DIV_W), .OVS(OVS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .div      (regs_q.div),
        .en       (regs_q.rx_en),
        .rxd      (rxd),
        .valid    (rx_valid),
        .ferr     (rx_ferr),
        .byte_out (rx_byte)
    );
endmodule

// File: rtl/sdp_checker.sv
module sdp_checker import sdp_pkg::*; #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              txd,
    input logic              rx_valid,
    input logic [31:0]       mask_q,
    input logic [31:0]       stat_q
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[SB_TX_IDLE] |-> txd); // R5

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_IEN))
        |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R3

    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_IDIS))
        |=> ((mask_q & $past(bus_wdata)) == 32'd0)); // R3

    AST_SEND_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_TXD) && stat_q[SB_TX_FREE])
        |=> (!stat_q[SB_TX_FREE] && !stat_q[SB_TX_IDLE])); // R4

    AST_READ_CLEARS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFF_RXD) && !rx_valid)
        |=> !stat_q[SB_RX_FULL]); // R8
endmodule

bind serial_dbg_port sdp_checker #(.ADDR_W(ADDR_W)) u_sdp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .txd       (txd),
    .rx_valid  (rx_valid),
    .mask_q    (regs_q.mask),
    .stat_q    (stat_vec)
);

// File: tb/serial_dbg_port_bench.sv
module serial_dbg_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txd, irq;
    logic        rxd = 1'b1;

    int n_checks = 0;
    int n_err = 0;
    logic run_cmp = 1'b0;
    logic rx_window = 1'b0;

    // behavioural model state
    logic        tbusy_m, txf_m, tx_en_m, rx_en_m, rxrdy_m, ovre_m, frame_m;
    logic [9:0]  tframe_m;
    int          tcnt_m, div_m;
    logic [31:0] mask_m;
    logic [7:0]  rhr_m;
    logic        busy_b, txf_b;

    always #2.5 clk = ~clk;

    serial_dbg_port #(.ADDR_W(6), .DIV_W(8), .OVS(16)) u_serial_dbg_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txd(txd), .rxd(rxd), .irq(irq)
    );

    function automatic logic [31:0] exp_stat();
        return (32'(txf_m) << 9) | (32'(frame_m) << 6) | (32'(ovre_m) << 5)
             | (32'(txf_m) << 1) | 32'(rxrdy_m);
    endfunction

    function automatic logic exp_txd();
        if (!tbusy_m) return 1'b1;
        return tframe_m[tcnt_m / (16 * div_m)];
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            tbusy_m = 0; txf_m = 1; tx_en_m = 1; rx_en_m = 1;
            rxrdy_m = 0; ovre_m = 0; frame_m = 0; tframe_m = '1;
            tcnt_m = 0; div_m = 0; mask_m = 0; rhr_m = 0;
        end else begin
            busy_b = tbusy_m;
            txf_b  = txf_m;
            if (tbusy_m) begin
                if (tcnt_m == 10 * 16 * div_m - 1) begin
                    tbusy_m = 0;
                    if (tx_en_m) txf_m = 1;
                end else begin
                    tcnt_m++;
                end
            end
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    6'h00: begin
                        if (bus_wdata[2] || bus_wdata[5]) rx_en_m = 0;
                        else if (bus_wdata[4])            rx_en_m = 1;
                        if (bus_wdata[3] || bus_wdata[7]) begin
                            tx_en_m = 0; txf_m = 0;
                            if (bus_wdata[3]) tbusy_m = 0;
                        end else if (bus_wdata[6]) begin
                            tx_en_m = 1;
                            if (!busy_b) txf_m = 1;
                        end
                        if (bus_wdata[8]) begin ovre_m = 0; frame_m = 0; end
                    end
                    6'h08: mask_m = mask_m | bus_wdata;
                    6'h0C: mask_m = mask_m & ~bus_wdata;
                    6'h1C: if (tx_en_m && txf_b) begin
                        tbusy_m = 1; tcnt_m = 0; txf_m = 0;
                        tframe_m = {1'b1, bus_wdata[7:0], 1'b0};
                    end
                    6'h20: div_m = int'(bus_wdata[7:0]);
                    default: ;
                endcase
            end
            if (bus_sel && !bus_wr && bus_addr == 6'h18) rxrdy_m = 0;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            check(32'(txd), 32'(exp_txd()), "R4 serial output per clock");
            if (!rx_window) check(32'(irq), 32'(|(mask_m & exp_stat())), "R12 interrupt per clock");
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        check(bus_rdata, exp, tag);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic stop_hi);
        logic [9:0] fr;
        fr = {stop_hi, b, 1'b0};
        rx_window = 1;
        for (int i = 0; i < 10; i++) begin
            rxd = fr[i];
            idle(16 * div_m);
        end
        rxd = 1;
        idle(20);
        if (rx_en_m) begin
            if (rxrdy_m) ovre_m = 1;
            if (!stop_hi) frame_m = 1;
            rhr_m = b;
            rxrdy_m = 1;
        end
        @(negedge clk);
        rx_window = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1;
        // R1 reset state
        check(32'(irq), 0, "R1 irq after reset");
        check(32'(txd), 1, "R1 txd after reset");
        rd(6'h14, 32'h202, "R1 status after reset");
        rd(6'h00, 0, "R1 control reads zero");
        rd(6'h04, 0, "R1 mode after reset");
        rd(6'h10, 0, "R1 mask after reset");
        rd(6'h18, 0, "R1 receive after reset");
        rd(6'h20, 0, "R1 divisor after reset");
        run_cmp = 1;
        // R2 readback
        wr(6'h20, 1);
        rd(6'h20, 1, "R2 divisor readback");
        wr(6'h04, 32'hA5C3_0F12);
        rd(6'h04, 32'hA5C3_0F12, "R2 mode readback");
        // R3 mask set/clear
        wr(6'h08, 32'h202);
        rd(6'h10, 32'h202, "R3 mask after set");
        check(32'(irq), 1, "R12 irq with transmitter flags masked");
        wr(6'h0C, 32'h200);
        rd(6'h10, 32'h2, "R3 mask after clear");
        wr(6'h10, 32'hFFFF);
        rd(6'h10, 32'h2, "R3 direct mask write ignored");
        // R4/R5/R6 transmit
        wr(6'h1C, 32'h5A);
        rd(6'h14, 32'h0, "R4 flags cleared by send");
        idle(40);
        wr(6'h1C, 32'h33);
        rd(6'h14, 32'h0, "R6 busy write ignored");
        idle(125);
        rd(6'h14, 32'h202, "R5 flags back after frame");
        check(32'(txd), 1, "R6 line idle, second byte dropped");
        wr(6'h20, 3);
        wr(6'h1C, 32'hC3);
        idle(300);
        rd(6'h14, 32'h0, "R5 flags low mid frame at divisor 3");
        idle(190);
        rd(6'h14, 32'h202, "R5 flags back at divisor 3");
        wr(6'h20, 1);
        // R7 disable/enable
        wr(6'h00, 32'h80);
        rd(6'h14, 32'h0, "R7 disable clears flags");
        wr(6'h1C, 32'h77);
        idle(20);
        check(32'(txd), 1, "R7 send while disabled ignored");
        wr(6'h00, 32'h40);
        rd(6'h14, 32'h202, "R7 enable sets flags");
        // R14 abort
        wr(6'h1C, 32'h00);
        idle(20);
        check(32'(txd), 0, "R14 byte in progress");
        wr(6'h00, 32'h08);
        rd(6'h14, 32'h0, "R14 abort clears flags");
        check(32'(txd), 1, "R14 line high after abort");
        wr(6'h00, 32'h40);
        rd(6'h14, 32'h202, "R14 re-enable after abort");
        // receive paths
        wr(6'h08, 32'h1);
        send(8'h96, 1);
        check(32'(irq), 1, "R12 irq on received byte");
        rd(6'h14, 32'h203, "R8 byte received");
        rd(6'h18, 32'h96, "R8 received value");
        rd(6'h14, 32'h202, "R8 read clears flag");
        send(8'h11, 1);
        send(8'h22, 1);
        rd(6'h14, 32'h223, "R9 overrun flagged");
        rd(6'h18, 32'h22, "R9 newest byte kept");
        wr(6'h00, 32'h100);
        rd(6'h14, 32'h202, "R11 status reset clears overrun");
        send(8'h44, 0);
        rd(6'h14, 32'h243, "R10 framing flagged");
        wr(6'h00, 32'h100);
        rd(6'h14, 32'h203, "R11 status reset keeps rx flag");
        rd(6'h18, 32'h44, "R10 byte loaded despite bad stop");
        wr(6'h00, 32'h20);
        idle(2);
        send(8'h55, 1);
        rd(6'h14, 32'h202, "R13 disabled receiver ignores byte");
        rd(6'h18, 32'h44, "R13 receive register unchanged");
        wr(6'h00, 32'h10);
        idle(2);
        send(8'h66, 1);
        rd(6'h14, 32'h203, "R13 re-enabled receiver");
        rd(6'h18, 32'h66, "R13 re-enabled value");
        idle(5);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule